// File: doc/BRIEF.md
# Eight-Instruction Multicycle Processor Core

A compact 32-bit core that runs an eight-instruction load/store instruction set. A control state machine carries each instruction through several cycles. The core fetches the word at the program counter and latches it as the instruction. In the next cycle it either completes the instruction or moves on to a memory-read or link phase. The register file has sixteen 32-bit entries, and entry zero is hard-wired to zero. A separate program counter counts words, not bytes.

The core has a single word-addressed memory port that serves both instruction fetch and data access. The port has an address, write data, a write strobe and read data. Read data comes back one cycle after the address is presented. When a halt instruction executes, the core raises its halted output. It then freezes until the next reset.

Top module: `octo_core`

## Requirements
- R1: The reset is asynchronous and active low. It clears the program counter to 0 and the halted output to 0. While reset is held, the core presents address 0 and does not assert the write strobe.
- R2: Reading register index 0 always returns zero. Any write aimed at index 0 is discarded.
- R3: The instruction word holds the opcode in bits 31..28, register A in 27..24, register B in 23..20, the destination in 3..0 and a 20-bit offset in 19..0. Opcode 0000 writes A+B to the destination. Opcode 0001 writes ~(A&B) to the destination. Opcode 0010 writes A plus the sign-extended offset into register B. All sums wrap modulo 2^32.
- R4: Opcode 0011 loads register B from memory word A+offset. Opcode 0100 stores register B to memory word A+offset. The offset is sign-extended from bit 19, and each store asserts the write strobe for exactly one cycle.
- R5: Opcode 0101 compares registers A and B. If they are equal, the next PC is PC+1+offset, where PC is the address of the branch itself. If they differ, the next PC is PC+1. Both forward and backward offsets work.
- R6: Opcode 0110 first writes PC+1 into register B. It then jumps to the value held in register A after that write. When A and B are the same register, execution therefore resumes at PC+1.
- R7: Opcode 0111 raises the halted output. From then until reset, the halted output stays high, the address output holds the halt instruction's address, and the write strobe stays low.
- R8: Opcodes 1000 through 1111 change no register and no memory word. They only advance the PC by one.
- R9: The all-zero word decodes as an add into register 0 and behaves as a no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_addr_o | output | 32 | Word address for fetch or data access |
| mem_wdata_o | output | 32 | Store data |
| mem_we_o | output | 1 | Write strobe |
| mem_rdata_i | input | 32 | Read data, valid one cycle after the address |
| halted_o | output | 1 | High once a halt has executed |

## Verification
The bench runs one program and reads back the words it stores. It targets these corner cases:

- A write to register 0. A core that keeps this write leaks a nonzero value into a later store.
- A sum that wraps past 2^32.
- Negative load and store offsets. A core that zero-extends the offset sends these to the wrong words.
- A taken forward branch that must skip a store, and a backward branch that closes a five-pass loop. An off-by-one target either leaves marker words written or gives the wrong count.
- Jump-and-link with equal link and target registers. A core that reads the target before writing the link skips the store at PC+1.
- Undefined opcodes whose fields name live registers. A core that executes them corrupts a register that is stored later.
- After the halt, the address is held and no write occurs. A core that keeps fetching moves the address or executes the store placed after the halt.

// File: rtl/octo_pkg.sv
package octo_pkg;
  localparam int OP_W  = 4;
  localparam int OFF_W = 20;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'b0000,
    OP_NAND = 4'b0001,
    OP_ADDI = 4'b0010,
    OP_LW   = 4'b0011,
    OP_SW   = 4'b0100,
    OP_BEQ  = 4'b0101,
    OP_JALR = 4'b0110,
    OP_HALT = 4'b0111
  } op_e;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_WB, ST_LINK, ST_HALT
  } state_e;

  typedef enum logic [1:0] {PC_HOLD, PC_INC, PC_BR, PC_REGA} pc_sel_e;
  typedef enum logic [1:0] {WD_ALU, WD_MEM, WD_LINK} wd_sel_e;
endpackage

// File: rtl/octo_regfile.sv
module octo_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 16,
  localparam int RW = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic [RW-1:0]   ra_i,
  input  logic [RW-1:0]   rb_i,
  output logic [XLEN-1:0] a_o,
  output logic [XLEN-1:0] b_o,
  input  logic            we_i,
  input  logic [RW-1:0]   wa_i,
  input  logic [XLEN-1:0] wd_i
);
  logic [XLEN-1:0] regs [NREG];

  assign regs[0] = '0;  // index 0 has no storage
  for (genvar i = 1; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk_i) begin
      if (we_i && wa_i == RW'(i)) regs[i] <= wd_i;
    end
  end

  assign a_o = regs[ra_i];
  assign b_o = regs[rb_i];
endmodule

// File: rtl/octo_alu.sv
module octo_alu
  import octo_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [XLEN-1:0] imm_i,
  output logic [XLEN-1:0] res_o,
  output logic [XLEN-1:0] addr_o,
  output logic            eq_o
);
  assign addr_o = a_i + imm_i;
  assign eq_o   = (a_i == b_i);

  always_comb begin
    unique case (op_i)
      OP_NAND: res_o = ~(a_i & b_i);
      OP_ADDI: res_o = addr_o;
      default: res_o = a_i + b_i;
    endcase
  end
endmodule

// File: rtl/octo_ctrl.sv
module octo_ctrl
  import octo_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] op_i,
  input  logic            eq_i,
  output state_e          state_o,
  output logic            ir_load_o,
  output logic            rf_we_o,
  output logic            wdst_b_o,
  output wd_sel_e         wd_sel_o,
  output pc_sel_e         pc_sel_o,
  output logic            addr_alu_o,
  output logic            mem_we_o,
  output logic            halt_set_o
);
  state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end
  assign state_o = state_q;

  always_comb begin
    state_d    = state_q;
    ir_load_o  = 1'b0;
    rf_we_o    = 1'b0;
    wdst_b_o   = 1'b0;
    wd_sel_o   = WD_ALU;
    pc_sel_o   = PC_HOLD;
    addr_alu_o = 1'b0;
    mem_we_o   = 1'b0;
    halt_set_o = 1'b0;
    unique case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: begin
        ir_load_o = 1'b1;
        state_d   = ST_EXEC;
      end
      ST_EXEC: begin
        state_d  = ST_FETCH;
        pc_sel_o = PC_INC;
        unique case (op_i)
          OP_ADD, OP_NAND: rf_we_o = 1'b1;
          OP_ADDI: begin
            rf_we_o  = 1'b1;
            wdst_b_o = 1'b1;
          end
          OP_LW: begin
            addr_alu_o = 1'b1;
            pc_sel_o   = PC_HOLD;
            state_d    = ST_WB;
          end
          OP_SW: begin
            addr_alu_o = 1'b1;
            mem_we_o   = 1'b1;
          end
          OP_BEQ:  pc_sel_o = eq_i ? PC_BR : PC_INC;
          OP_JALR: begin  // link first, target read next cycle
            rf_we_o  = 1'b1;
            wdst_b_o = 1'b1;
            wd_sel_o = WD_LINK;
            pc_sel_o = PC_HOLD;
            state_d  = ST_LINK;
          end
          OP_HALT: begin
            pc_sel_o   = PC_HOLD;
            halt_set_o = 1'b1;
            state_d    = ST_HALT;
          end
          default: ;  // undefined opcodes advance only
        endcase
      end
      ST_WB: begin
        rf_we_o  = 1'b1;
        wdst_b_o = 1'b1;
        wd_sel_o = WD_MEM;
        pc_sel_o = PC_INC;
        state_d  = ST_FETCH;
      end
      ST_LINK: begin
        pc_sel_o = PC_REGA;
        state_d  = ST_FETCH;
      end
      default: state_d = ST_HALT;
    endcase
  end
endmodule

// File: rtl/octo_core.sv
module octo_core
  import octo_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [XLEN-1:0] mem_wdata_o,
  output logic            mem_we_o,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic            halted_o
);
  localparam int RW = $clog2(NREG);

  logic [XLEN-1:0] pc_q, ir_q, imm, a_data, b_data, alu_res, alu_addr, wd;
  logic [RW-1:0]   ra_idx, rb_idx, rd_idx, wa;
  logic [OP_W-1:0] opcode;
  logic            halted_q, eq;
  logic            ir_load, rf_we, wdst_b, addr_alu, ctl_we, halt_set;
  state_e          state;
  wd_sel_e         wd_sel;
  pc_sel_e         pc_sel;

  assign opcode = ir_q[31:28];
  assign ra_idx = ir_q[24 +: RW];
  assign rb_idx = ir_q[20 +: RW];
  assign rd_idx = ir_q[0 +: RW];
  assign imm    = {{(XLEN-OFF_W){ir_q[OFF_W-1]}}, ir_q[OFF_W-1:0]};

  octo_ctrl i_ctrl (
    .clk_i, .rst_ni, .op_i(opcode), .eq_i(eq), .state_o(state),
    .ir_load_o(ir_load), .rf_we_o(rf_we), .wdst_b_o(wdst_b), .wd_sel_o(wd_sel),
    .pc_sel_o(pc_sel), .addr_alu_o(addr_alu), .mem_we_o(ctl_we),
    .halt_set_o(halt_set)
  );

  octo_alu #(.XLEN(XLEN)) i_alu (
    .op_i(opcode), .a_i(a_data), .b_i(b_data), .imm_i(imm),
    .res_o(alu_res), .addr_o(alu_addr), .eq_o(eq)
  );

  always_comb begin
    unique case (wd_sel)
      WD_MEM:  wd = mem_rdata_i;
      WD_LINK: wd = pc_q + XLEN'(1);
      default: wd = alu_res;
    endcase
  end
  assign wa = wdst_b ? rb_idx : rd_idx;

  octo_regfile #(.XLEN(XLEN), .NREG(NREG)) i_rf (
    .clk_i, .ra_i(ra_idx), .rb_i(rb_idx), .a_o(a_data), .b_o(b_data),
    .we_i(rf_we), .wa_i(wa), .wd_i(wd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= '0;
      ir_q     <= '0;
      halted_q <= 1'b0;
    end else begin
      if (ir_load) ir_q <= mem_rdata_i;
      if (halt_set) halted_q <= 1'b1;
      unique case (pc_sel)
        PC_INC:  pc_q <= pc_q + XLEN'(1);
        PC_BR:   pc_q <= pc_q + XLEN'(1) + imm;
        PC_REGA: pc_q <= a_data;
        default: ;
      endcase
    end
  end

  assign mem_addr_o  = addr_alu ? alu_addr : pc_q;
  assign mem_wdata_o = b_data;
  assign mem_we_o    = ctl_we && (state == ST_EXEC);
  assign halted_o    = halted_q;
endmodule

// File: rtl/octo_core_chk.sv
module octo_core_chk #(
  parameter int XLEN = 32,
  parameter int RW   = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [XLEN-1:0] mem_addr_o,
  input logic            mem_we_o,
  input logic            halted_o,
  input logic [RW-1:0]   rf_idx,
  input logic [XLEN-1:0] rf_data
);
  assert_zero_reg_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_idx == '0) |-> (rf_data == '0));

  assert_single_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);

  assert_halt_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o);

  assert_halt_no_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !mem_we_o);

  assert_halt_addr_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && $past(halted_o)) |-> $stable(mem_addr_o));
endmodule

bind octo_core octo_core_chk #(.XLEN(XLEN), .RW(RW)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_addr_o(mem_addr_o),
  .mem_we_o(mem_we_o), .halted_o(halted_o), .rf_idx(ra_idx), .rf_data(a_data)
);

// File: tb/test_octo_core.sv
`timescale 1ns/1ps
module test_octo_core;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] addr, wdata, rdata;
  logic        we, halted;
  logic [31:0] mem [256];
  int          n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  octo_core i_octo_core (
    .clk_i(clk), .rst_ni(rst_n), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_we_o(we), .mem_rdata_i(rdata), .halted_o(halted)
  );

  always @(posedge clk) begin
    if (we) mem[addr[7:0]] <= wdata;
    rdata <= mem[addr[7:0]];
  end

  function automatic logic [31:0] er(int op, int a, int b, int d);
    return {op[3:0], a[3:0], b[3:0], 16'h0, d[3:0]};
  endfunction
  function automatic logic [31:0] ei(int op, int a, int b, int off);
    return {op[3:0], a[3:0], b[3:0], off[19:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // {address, expected word, requirement number}
  localparam logic [47:0] VEC [14] = '{
    {8'hA0, 32'h0000_0000, 8'd2},  // R2 write to r0 dropped
    {8'hA1, 32'h0000_0002, 8'd3},  // R3 add
    {8'hA2, 32'hFFFF_FFFA, 8'd3},  // R3 nand
    {8'hA3, 32'h0000_0001, 8'd3},  // R3 wrap
    {8'hA4, 32'hFFFF_FFFF, 8'd4},  // R4 store, negative offset
    {8'hA9, 32'hFFFF_FFFF, 8'd4},  // R4 load, negative offset
    {8'hA5, 32'h0000_0000, 8'd5},  // R5 skipped by taken branch
    {8'hA6, 32'h0000_0005, 8'd5},  // R5 branch target
    {8'hAB, 32'h0000_0005, 8'd5},  // R5 backward loop count
    {8'hA7, 32'h0000_0000, 8'd6},  // R6 skipped by jump
    {8'hA8, 32'h0000_0015, 8'd6},  // R6 link = 21
    {8'hAA, 32'h0000_001A, 8'd6},  // R6 same register -> PC+1
    {8'hAD, 32'h0000_00A8, 8'd8},  // R8 undefined opcode left r7
    {8'hAE, 32'h0000_0005, 8'd9}   // R9 zero word passed
  };

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[8'h81] = 32'hFFFF_FFFF;
    mem[0]  = ei(2, 0, 1, 5);
    mem[1]  = ei(2, 0, 2, -3);
    mem[2]  = er(0, 1, 2, 3);
    mem[3]  = er(1, 1, 2, 4);
    mem[4]  = ei(2, 1, 0, 7);
    mem[5]  = ei(4, 0, 0, 'hA0);
    mem[6]  = ei(4, 0, 3, 'hA1);
    mem[7]  = ei(4, 0, 4, 'hA2);
    mem[8]  = ei(3, 0, 5, 'h81);
    mem[9]  = ei(2, 5, 6, 2);
    mem[10] = ei(4, 0, 6, 'hA3);
    mem[11] = ei(2, 0, 7, 'hA8);
    mem[12] = ei(4, 7, 5, -4);
    mem[13] = ei(3, 7, 8, -4);
    mem[14] = ei(4, 7, 8, 1);
    mem[15] = ei(5, 1, 2, 5);
    mem[16] = ei(5, 3, 3, 1);
    mem[17] = ei(4, 0, 1, 'hA5);
    mem[18] = ei(4, 0, 1, 'hA6);
    mem[19] = ei(2, 0, 9, 23);
    mem[20] = ei(6, 9, 10, 0);
    mem[21] = ei(4, 0, 1, 'hA7);
    mem[22] = ei(7, 0, 0, 0);
    mem[23] = ei(4, 0, 10, 'hA8);
    mem[24] = ei(2, 0, 11, 27);
    mem[25] = ei(6, 11, 11, 0);
    mem[26] = ei(4, 0, 11, 'hAA);
    mem[27] = 32'h8000_0000;
    mem[28] = 32'hF123_4567;
    mem[29] = 32'h0000_0000;
    mem[30] = ei(4, 0, 1, 'hAE);
    mem[31] = er(0, 0, 0, 13);
    mem[32] = ei(2, 13, 13, 1);
    mem[33] = ei(5, 13, 1, 1);
    mem[34] = ei(5, 0, 0, -3);
    mem[35] = ei(4, 0, 13, 'hAB);
    mem[36] = ei(4, 0, 7, 'hAD);
    mem[37] = ei(7, 0, 0, 0);
    mem[38] = ei(4, 0, 1, 'hAC);

    repeat (3) @(negedge clk);
    check("R1 addr", addr, 32'h0);
    check("R1 we", {31'h0, we}, 32'h0);
    check("R1 halted", {31'h0, halted}, 32'h0);
    rst_n = 1'b1;

    begin : run
      int cyc = 0;
      while (!halted && cyc < 5000) begin
        @(negedge clk);
        cyc++;
      end
      if (!halted) begin
        n_chk++; n_bad++;
        $display("FAIL R7 watchdog: actual no halt expected halt");
      end
    end

    for (int i = 0; i < 14; i++) begin
      string tag;
      tag = $sformatf("R%0d @%h", VEC[i][7:0], VEC[i][47:40]);
      check(tag, mem[VEC[i][47:40]], VEC[i][39:8]);
    end

    // R7: frozen after halt, store behind the halt never runs
    begin : frozen
      logic seen_we = 1'b0;
      logic moved = 1'b0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (we) seen_we = 1'b1;
        if (addr !== 32'd37) moved = 1'b1;
      end
      check("R7 addr held", {31'h0, moved}, 32'h0);
      check("R7 no write", {31'h0, seen_we}, 32'h0);
      check("R7 halted", {31'h0, halted}, 32'h1);
      check("R7 no store after halt", mem[8'hAC], 32'h0);
    end

    // R1: reset releases the halt and restarts at 0
    rst_n = 1'b0;
    #1;
    check("R1 rereset halted", {31'h0, halted}, 32'h0);
    check("R1 rereset addr", addr, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule